// File: doc/BRIEF.md
# MDIO Management Target

This block lets an external management controller reach a small set of status and control registers over the two-wire MDIO/MDC bus, using the clause-22 frame layout. A faster system clock oversamples both MDC and MDIO. The block finds each MDC rising edge and takes one frame bit at that edge. It walks through the frame fields and, for a read, returns register contents on MDIO through an output-enable. At every other time the line is left released.

The block holds a configurable number of ports. Port `i` answers at PHY address `BASE_ADDR + i`. Each port has a sparse window of eight 16-bit registers, kept as plain writable storage. Before the block decodes anything, it insists on a full preamble run of ones. After each frame it hunts for a fresh preamble.

Top module: `mdio_target`

## Requirements
- R1: After reset, `mdio_oe` is low and every register of every port reads back as 0x0000.
- R2: No frame is decoded until at least 32 consecutive ones have been sampled. A frame after only 31 ones has no effect: a write is not stored and a read never drives the line. Any run longer than 32 ones is accepted.
- R3: After the preamble, the start field must be `01` and the opcode must be `10` (read) or `01` (write). Any other start or opcode value abandons the frame with no write and no drive, and the block returns to preamble hunting.
- R4: The 5-bit PHY address and the 5-bit register address are taken MSB first. Port `i` responds only at PHY address `BASE_ADDR + i` (defaults: 2 ports, base 4), and its registers are separate from those of every other port.
- R5: On a read to an implemented register, `mdio_oe` is low at the first turnaround bit. At the second turnaround bit the block drives 0.
- R6: On a read, the 16 data bits are driven bit 15 first, one per MDC cycle, and each bit is stable at the MDC rising edge where it is sampled.
- R7: On a write, the 16 data bits following the turnaround (MSB first) are stored in the addressed register, and `mdio_oe` stays low for the entire frame.
- R8: Implemented register addresses are 0x00 through 0x05, 0x1D and 0x1F. A read of any other address leaves `mdio_oe` low for the whole frame. A write to such an address changes no register.
- R9: A frame carrying a PHY address that matches no port is consumed without driving the line and without changing any register.
- R10: After the last data bit, the block releases MDIO before the next MDC rising edge. A frame that follows without a new 32-one preamble is ignored.
- R11: Reads and writes work with MDC at one quarter of the system clock. The drive value changes only in the system cycle right after a detected MDC rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least four times the MDC rate |
| rst_n | input | 1 | Synchronous active-low reset |
| mdc | input | 1 | Management clock from the controller (asynchronous) |
| mdio_in | input | 1 | Level seen on the shared MDIO line |
| mdio_out | output | 1 | Value the block drives while `mdio_oe` is high |
| mdio_oe | output | 1 | High while the block drives MDIO |

## Verification
Two events can land on the same MDC rising edge. The first is the block sampling its final data bit and releasing the line. The second is the block adding that same idle bit to a new preamble count. The bench provokes this by following a full frame straight away with a second frame that has no preamble, and it judges the result by reading back both target registers. A second collision occurs at the fastest legal MDC rate. There, the synchroniser delay plus the drive update must fit inside one MDC period. The bench runs a write and read-back with MDC at four system clocks per period and compares each sampled bit with the expected value.

// File: rtl/mdio_tgt_pkg.sv
// Shared types and the register-window decode for the MDIO target.
// Assumes clause-22 5-bit register addresses.
package mdio_tgt_pkg;

    localparam int REG_IDX_W = 3;
    localparam int REGS_PER_PORT = 1 << REG_IDX_W;

    typedef enum logic [2:0] {
        ST_HUNT,   // counting preamble ones
        ST_SOF,    // second start bit expected
        ST_OPC,    // two opcode bits
        ST_ADDR,   // PHY and register address, 10 bits
        ST_TURN,   // two turnaround bits
        ST_DATA    // 16 data bits
    } frame_st_e;

    // Map a bus register address onto a storage slot; bit 3 flags a valid slot.
    function automatic logic [REG_IDX_W:0] map_reg(input logic [4:0] ra);
        logic [REG_IDX_W:0] r;
        r = '0;
        if (ra <= 5'h05)      r = {1'b1, ra[REG_IDX_W-1:0]};
        else if (ra == 5'h1D) r = {1'b1, 3'd6};
        else if (ra == 5'h1F) r = {1'b1, 3'd7};
        return r;
    endfunction

endpackage

// File: rtl/mdio_edge_sync.sv
// Brings MDC and MDIO into the system clock domain and flags MDC rising edges.
// Assumes clk is at least four times MDC, so every MDC level lasts 2+ cycles.
// bit_in is delayed exactly like the MDC copy that produces bit_stb.
module mdio_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mdc,
    input  logic mdio_in,
    output logic bit_stb,
    output logic bit_in
);

    logic [STAGES:0]   mdc_sh;
    logic [STAGES-1:0] dat_sh;

    // Shift both lines through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mdc_sh <= '1;
            dat_sh <= '1;
        end else begin
            mdc_sh <= {mdc_sh[STAGES-1:0], mdc};
            dat_sh <= {dat_sh[STAGES-2:0], mdio_in};
        end
    end

    // A low-to-high step in the synchronised MDC marks one frame bit.
    always_comb begin
        bit_stb = mdc_sh[STAGES-1] & ~mdc_sh[STAGES];
        bit_in  = dat_sh[STAGES-1];
    end

endmodule

// File: rtl/mdio_frame_fsm.sv
// Frame decoder for the MDIO target: preamble hunt, start, opcode, addresses,
// turnaround and data. It acts only on bit_stb cycles and registers its drive
// outputs, so they change one cycle after the strobe.
// Assumes rd_data reflects sel_port/sel_idx combinationally.
module mdio_frame_fsm
    import mdio_tgt_pkg::*;
#(
    parameter int NUM_PORTS    = 2,
    parameter int BASE_ADDR    = 4,
    parameter int PREAMBLE_LEN = 32,
    parameter int DATA_W       = 16,
    localparam int PORT_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
    localparam int PCW    = $clog2(PREAMBLE_LEN + 1),
    localparam int DCW    = $clog2(DATA_W) + 1,
    localparam int CW     = (PCW > DCW) ? PCW : DCW
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bit_stb,
    input  logic                 bit_in,
    input  logic [DATA_W-1:0]    rd_data,
    output logic [PORT_W-1:0]    sel_port,
    output logic [REG_IDX_W-1:0] sel_idx,
    output logic                 wr_en,
    output logic [DATA_W-1:0]    wr_data,
    output logic                 drv_oe,
    output logic                 drv_val,
    output frame_st_e            state_o
);

    frame_st_e              st;
    logic [CW-1:0]          cnt;
    logic                   opc_hi;
    logic [9:0]             addr_sh;
    logic [9:0]             addr_nxt;
    logic [4:0]             rel;
    logic [REG_IDX_W:0]     slot;
    logic                   phy_ok;
    logic                   rd_op;
    logic                   hit;
    logic [PORT_W-1:0]      port_q;
    logic [REG_IDX_W-1:0]   idx_q;
    logic [DATA_W-1:0]      dsh;

    // Decode the address field as it completes with the current bit.
    always_comb begin
        addr_nxt = {addr_sh[8:0], bit_in};
        rel      = addr_nxt[9:5] - 5'(BASE_ADDR);
        phy_ok   = (addr_nxt[9:5] >= 5'(BASE_ADDR)) && (int'(rel) < NUM_PORTS);
        slot     = map_reg(addr_nxt[4:0]);
    end

    // Walk the frame one MDC bit at a time and produce drive and write pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_HUNT;
            cnt     <= '0;
            opc_hi  <= 1'b0;
            addr_sh <= '0;
            rd_op   <= 1'b0;
            hit     <= 1'b0;
            port_q  <= '0;
            idx_q   <= '0;
            dsh     <= '0;
            drv_oe  <= 1'b0;
            drv_val <= 1'b0;
            wr_en   <= 1'b0;
            wr_data <= '0;
        end else begin
            wr_en <= 1'b0;
            if (bit_stb) begin
                unique case (st)
                    ST_HUNT: begin
                        if (bit_in) begin
                            if (cnt < CW'(PREAMBLE_LEN)) cnt <= cnt + 1'b1;
                        end else begin
                            if (cnt == CW'(PREAMBLE_LEN)) st <= ST_SOF;
                            cnt <= '0;
                        end
                    end
                    ST_SOF: begin
                        st <= bit_in ? ST_OPC : ST_HUNT;
                    end
                    ST_OPC: begin
                        opc_hi <= bit_in;
                        if (cnt == CW'(1)) begin
                            cnt <= '0;
                            if (opc_hi != bit_in) begin
                                st    <= ST_ADDR;
                                rd_op <= opc_hi;
                            end else begin
                                st <= ST_HUNT;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_ADDR: begin
                        addr_sh <= addr_nxt;
                        if (cnt == CW'(9)) begin
                            cnt    <= '0;
                            st     <= ST_TURN;
                            hit    <= phy_ok & slot[REG_IDX_W];
                            port_q <= rel[PORT_W-1:0];
                            idx_q  <= slot[REG_IDX_W-1:0];
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    ST_TURN: begin
                        if (cnt == '0) begin
                            cnt <= cnt + 1'b1;
                            if (rd_op && hit) begin
                                drv_oe  <= 1'b1;
                                drv_val <= 1'b0;
                            end
                        end else begin
                            cnt     <= '0;
                            st      <= ST_DATA;
                            dsh     <= {rd_data[DATA_W-2:0], 1'b0};
                            drv_val <= rd_data[DATA_W-1];
                        end
                    end
                    ST_DATA: begin
                        if (rd_op) begin
                            drv_val <= dsh[DATA_W-1];
                            dsh     <= {dsh[DATA_W-2:0], 1'b0};
                        end else begin
                            dsh <= {dsh[DATA_W-2:0], bit_in};
                        end
                        if (cnt == CW'(DATA_W - 1)) begin
                            cnt    <= '0;
                            st     <= ST_HUNT;
                            drv_oe <= 1'b0;
                            if (!rd_op && hit) begin
                                wr_en   <= 1'b1;
                                wr_data <= {dsh[DATA_W-2:0], bit_in};
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    default: begin
                        st  <= ST_HUNT;
                        cnt <= '0;
                    end
                endcase
            end
        end
    end

    // Expose the latched selection and state to the neighbours.
    always_comb begin
        sel_port = port_q;
        sel_idx  = idx_q;
        state_o  = st;
    end

endmodule

// File: rtl/mdio_reg_bank.sv
// Per-port register storage for the MDIO target: NUM_PORTS x REGS_PER_PORT
// words, one shared select for read and write. Assumes the writer only
// presents in-range ports; reads from out-of-range ports return zero.
module mdio_reg_bank
    import mdio_tgt_pkg::*;
#(
    parameter int NUM_PORTS = 2,
    parameter int DATA_W    = 16,
    localparam int PORT_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [PORT_W-1:0]    sel_port,
    input  logic [REG_IDX_W-1:0] sel_idx,
    input  logic [DATA_W-1:0]    wr_data,
    output logic [DATA_W-1:0]    rd_data
);

    logic [DATA_W-1:0] cells [NUM_PORTS][REGS_PER_PORT];

    // Clear every word on reset; store one word per write pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int p = 0; p < NUM_PORTS; p++) begin
                for (int r = 0; r < REGS_PER_PORT; r++) begin
                    cells[p][r] <= '0;
                end
            end
        end else if (wr_en && (int'(sel_port) < NUM_PORTS)) begin
            cells[sel_port][sel_idx] <= wr_data;
        end
    end

    // Return the selected word, zero for a port outside the array.
    always_comb begin
        rd_data = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (int'(sel_port) == p) rd_data = cells[p][sel_idx];
        end
    end

endmodule

// File: rtl/mdio_target.sv
// Top of the MDIO management target. It chains the synchroniser, the frame
// decoder and the register storage. Assumes clk >= 4 x MDC and an external
// pull-up on MDIO; mdio_out is meaningful only while mdio_oe is high.
module mdio_target
    import mdio_tgt_pkg::*;
#(
    parameter int NUM_PORTS   = 2,
    parameter int BASE_ADDR   = 4,
    parameter int SYNC_STAGES = 2,
    localparam int DATA_W = 16,
    localparam int PORT_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mdc,
    input  logic mdio_in,
    output logic mdio_out,
    output logic mdio_oe
);

    logic                 mdc_rise;
    logic                 samp_bit;
    logic [PORT_W-1:0]    sel_port;
    logic [REG_IDX_W-1:0] sel_idx;
    logic                 wr_en;
    logic [DATA_W-1:0]    wr_data;
    logic [DATA_W-1:0]    rd_data;
    frame_st_e            fsm_state;

    mdio_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .mdc     (mdc),
        .mdio_in (mdio_in),
        .bit_stb (mdc_rise),
        .bit_in  (samp_bit)
    );

    mdio_frame_fsm #(
        .NUM_PORTS    (NUM_PORTS),
        .BASE_ADDR    (BASE_ADDR),
        .PREAMBLE_LEN (32),
        .DATA_W       (DATA_W)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_stb  (mdc_rise),
        .bit_in   (samp_bit),
        .rd_data  (rd_data),
        .sel_port (sel_port),
        .sel_idx  (sel_idx),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .drv_oe   (mdio_oe),
        .drv_val  (mdio_out),
        .state_o  (fsm_state)
    );

    mdio_reg_bank #(
        .NUM_PORTS (NUM_PORTS),
        .DATA_W    (DATA_W)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .sel_port (sel_port),
        .sel_idx  (sel_idx),
        .wr_data  (wr_data),
        .rd_data  (rd_data)
    );

endmodule

// File: rtl/mdio_target_chk.sv
// Protocol checker bound into mdio_target. It watches the drive outputs
// against the edge strobe and the decoder state, and the write pulses
// against the port range.
module mdio_target_chk
    import mdio_tgt_pkg::*;
#(
    parameter int NUM_PORTS = 2,
    parameter int PORT_W    = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mdc_rise,
    input logic              wr_en,
    input logic [PORT_W-1:0] sel_port,
    input logic              mdio_oe,
    input logic              mdio_out,
    input frame_st_e         fsm_state
);

    // R11: the output enable only moves in the cycle after an MDC edge strobe.
    assert_oe_on_edge_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mdio_oe != $past(mdio_oe)) |-> $past(mdc_rise));

    // R5: the first driven bit of a read is the turnaround zero.
    assert_turn_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdio_oe) |-> !mdio_out);

    // R10: the line is driven only inside turnaround or data.
    assert_drive_in_frame_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mdio_oe |-> (fsm_state == ST_TURN || fsm_state == ST_DATA));

    // R9: a store only ever targets an existing port.
    assert_write_port_ok_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (int'(sel_port) < NUM_PORTS));

    // R7: one write frame stores exactly once.
    assert_write_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);

    // R7: a write never coincides with the block driving the line.
    assert_write_not_driving_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !mdio_oe);

endmodule

bind mdio_target mdio_target_chk #(
    .NUM_PORTS (NUM_PORTS),
    .PORT_W    (PORT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mdc_rise  (mdc_rise),
    .wr_en     (wr_en),
    .sel_port  (sel_port),
    .mdio_oe   (mdio_oe),
    .mdio_out  (mdio_out),
    .fsm_state (fsm_state)
);

// File: tb/tb_mdio_target.sv
// Directed bench for mdio_target: acts as the management controller and
// checks each scenario in its own task.
module tb_mdio_target;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mdc = 1'b0;
    logic ctrl_drv = 1'b0;
    logic ctrl_val = 1'b1;
    logic mdio_out;
    logic mdio_oe;
    logic line;

    int checks_run = 0;
    int checks_bad = 0;
    int lo_cyc = 4;
    int hi_cyc = 4;

    // Results of the most recent frame.
    logic [15:0] fr_rdat;
    logic fr_ta1_oe, fr_ta2_zero, fr_all_drv, fr_any_drv, fr_idle_oe;

    always #10 clk = ~clk;

    // Shared line with pull-up: target wins when enabled, else controller.
    assign line = mdio_oe ? mdio_out : (ctrl_drv ? ctrl_val : 1'b1);

    mdio_target dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .mdc      (mdc),
        .mdio_in  (line),
        .mdio_out (mdio_out),
        .mdio_oe  (mdio_oe)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks_run++;
        if (act !== exp) begin
            checks_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // One MDC period: set line while MDC low, then sample line and enable at the rise.
    task automatic mdc_bit(input logic drv, input logic val,
                           output logic smp, output logic toe);
        mdc = 1'b0;
        ctrl_drv = drv;
        ctrl_val = val;
        repeat (lo_cyc) @(negedge clk);
        smp = line;
        toe = mdio_oe;
        mdc = 1'b1;
        repeat (hi_cyc) @(negedge clk);
    endtask

    function automatic logic [4:0] win_addr(input int i);
        if (i < 6) return 5'(i);
        return (i == 6) ? 5'h1D : 5'h1F;
    endfunction

    task automatic run_frame(input int pre_len, input bit lead_zero,
                             input logic [1:0] sof, input logic [1:0] opc,
                             input logic [4:0] phy, input logic [4:0] ra,
                             input logic [15:0] wdat);
        logic s, o;
        logic [13:0] hdr;
        bit is_rd;
        is_rd = (opc == 2'b10);
        hdr = {sof, opc, phy, ra};
        fr_any_drv = 1'b0;
        fr_all_drv = 1'b1;
        fr_rdat = '0;
        if (lead_zero) begin
            mdc_bit(1'b1, 1'b0, s, o);
            fr_any_drv |= o;
        end
        for (int i = 0; i < pre_len; i++) begin
            mdc_bit(1'b1, 1'b1, s, o);
            fr_any_drv |= o;
        end
        for (int i = 13; i >= 0; i--) begin
            mdc_bit(1'b1, hdr[i], s, o);
            fr_any_drv |= o;
        end
        if (is_rd) begin
            mdc_bit(1'b0, 1'b0, s, o);
            fr_ta1_oe = o;
            fr_any_drv |= o;
            mdc_bit(1'b0, 1'b0, s, o);
            fr_ta2_zero = o && (s == 1'b0);
            fr_any_drv |= o;
            fr_all_drv &= o;
        end else begin
            mdc_bit(1'b1, 1'b1, s, o);
            fr_ta1_oe = o;
            fr_any_drv |= o;
            mdc_bit(1'b1, 1'b0, s, o);
            fr_ta2_zero = 1'b0;
            fr_any_drv |= o;
        end
        for (int i = 15; i >= 0; i--) begin
            mdc_bit(!is_rd, wdat[i], s, o);
            fr_rdat[i] = s;
            fr_any_drv |= o;
            fr_all_drv &= o;
        end
        mdc_bit(1'b0, 1'b1, s, o);
        fr_idle_oe = o;
    endtask

    task automatic do_wr(input logic [4:0] phy, input logic [4:0] ra, input logic [15:0] d);
        run_frame(32, 1'b1, 2'b01, 2'b01, phy, ra, d);
    endtask

    task automatic do_rd(input logic [4:0] phy, input logic [4:0] ra);
        run_frame(32, 1'b1, 2'b01, 2'b10, phy, ra, 16'h0000);
    endtask

    task automatic expect_rd(input string req, input logic [4:0] phy,
                             input logic [4:0] ra, input logic [15:0] exp);
        do_rd(phy, ra);
        check(req, $sformatf("read data phy %0d reg %h", phy, ra), {16'd0, fr_rdat}, {16'd0, exp});
        check(req, "read drives every data bit", {31'd0, fr_all_drv}, 32'd1);
    endtask

    task automatic t_reset();
        check("R1", "mdio_oe after reset", {31'd0, mdio_oe}, 32'd0);
        expect_rd("R1", 5'd4, 5'h00, 16'h0000);
        expect_rd("R1", 5'd5, 5'h1F, 16'h0000);
    endtask

    task automatic t_basic();
        do_wr(5'd4, 5'h1D, 16'hA5C3);
        check("R7", "write frame never drives", {31'd0, fr_any_drv}, 32'd0);
        do_rd(5'd4, 5'h1D);
        check("R6", "read data msb first", {16'd0, fr_rdat}, 32'h0000A5C3);
        check("R5", "first turnaround bit released", {31'd0, fr_ta1_oe}, 32'd0);
        check("R5", "second turnaround bit driven zero", {31'd0, fr_ta2_zero}, 32'd1);
        check("R6", "all data bits driven", {31'd0, fr_all_drv}, 32'd1);
        check("R10", "released after data", {31'd0, fr_idle_oe}, 32'd0);
        expect_rd("R4", 5'd5, 5'h1D, 16'h0000);
    endtask

    task automatic t_window();
        for (int i = 0; i < 8; i++) do_wr(5'd5, win_addr(i), 16'h1000 + 16'(i) * 16'h0111);
        for (int i = 0; i < 8; i++) expect_rd("R8", 5'd5, win_addr(i), 16'h1000 + 16'(i) * 16'h0111);
        expect_rd("R4", 5'd4, 5'h1D, 16'hA5C3);
    endtask

    task automatic t_unmapped();
        do_wr(5'd4, 5'h06, 16'h5A5A);
        do_wr(5'd4, 5'h1E, 16'h5A5A);
        do_rd(5'd4, 5'h06);
        check("R8", "read of reg 06 never drives", {31'd0, fr_any_drv}, 32'd0);
        do_rd(5'd4, 5'h1E);
        check("R8", "read of reg 1E never drives", {31'd0, fr_any_drv}, 32'd0);
        expect_rd("R8", 5'd4, 5'h00, 16'h0000);
        expect_rd("R8", 5'd4, 5'h1F, 16'h0000);
        expect_rd("R8", 5'd4, 5'h1D, 16'hA5C3);
    endtask

    task automatic t_phy();
        do_wr(5'd6, 5'h00, 16'hBEEF);
        do_wr(5'd3, 5'h01, 16'hBEEF);
        do_rd(5'd6, 5'h00);
        check("R9", "unmatched phy 6 never drives", {31'd0, fr_any_drv}, 32'd0);
        do_rd(5'd0, 5'h00);
        check("R9", "unmatched phy 0 never drives", {31'd0, fr_any_drv}, 32'd0);
        expect_rd("R9", 5'd4, 5'h00, 16'h0000);
        expect_rd("R9", 5'd5, 5'h01, 16'h1111);
    endtask

    task automatic t_preamble();
        run_frame(31, 1'b1, 2'b01, 2'b01, 5'd4, 5'h02, 16'h1234);
        run_frame(31, 1'b1, 2'b01, 2'b10, 5'd4, 5'h1D, 16'h0000);
        check("R2", "31-one read never drives", {31'd0, fr_any_drv}, 32'd0);
        expect_rd("R2", 5'd4, 5'h02, 16'h0000);
        run_frame(40, 1'b1, 2'b01, 2'b01, 5'd4, 5'h02, 16'h4321);
        expect_rd("R2", 5'd4, 5'h02, 16'h4321);
    endtask

    task automatic t_bad_fields();
        run_frame(32, 1'b1, 2'b00, 2'b01, 5'd4, 5'h03, 16'h7E7E);
        run_frame(32, 1'b1, 2'b01, 2'b11, 5'd4, 5'h04, 16'h6C6C);
        run_frame(32, 1'b1, 2'b01, 2'b00, 5'd4, 5'h05, 16'h3C3C);
        check("R3", "bad opcode frame never drives", {31'd0, fr_any_drv}, 32'd0);
        expect_rd("R3", 5'd4, 5'h03, 16'h0000);
        expect_rd("R3", 5'd4, 5'h04, 16'h0000);
        expect_rd("R3", 5'd4, 5'h05, 16'h0000);
    endtask

    task automatic t_back_to_back();
        do_wr(5'd4, 5'h01, 16'h0F0F);
        run_frame(0, 1'b0, 2'b01, 2'b01, 5'd4, 5'h00, 16'hC0DE);
        expect_rd("R10", 5'd4, 5'h00, 16'h0000);
        expect_rd("R10", 5'd4, 5'h01, 16'h0F0F);
    endtask

    task automatic t_fast_mdc();
        lo_cyc = 2;
        hi_cyc = 2;
        do_wr(5'd5, 5'h1F, 16'h6B2D);
        do_rd(5'd5, 5'h1F);
        check("R11", "read at clk/4 MDC", {16'd0, fr_rdat}, 32'h00006B2D);
        check("R11", "turnaround zero at clk/4 MDC", {31'd0, fr_ta2_zero}, 32'd1);
        check("R11", "release at clk/4 MDC", {31'd0, fr_idle_oe}, 32'd0);
        lo_cyc = 4;
        hi_cyc = 4;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        checks_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks_run, checks_bad);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset();
        t_basic();
        t_window();
        t_unmapped();
        t_phy();
        t_preamble();
        t_bad_fields();
        t_back_to_back();
        t_fast_mdc();
        $display("End of test - %0d assertions evaluated, %0d failures", checks_run, checks_bad);
        $finish;
    end

endmodule